// File: doc/BRIEF.md
# Surplus Energy Load Diverter

The block keeps a single bounded energy level that collects the real power contributions reported for each phase. Once per mains cycle it decides whether to switch one of several dump loads on or off, so that surplus energy is used locally rather than exported. The decision uses one threshold at the middle of the range. After each crossing of that threshold there is a settling delay. Anti-flicker rules let only the most recently switched load toggle immediately. Any other load must wait out a spacing interval, and the energy must also be moving in the direction that calls for the change.

A selector input, filtered over many half cycles, chooses which of the first two loads has the higher priority. The block swaps their physical drive lines when that selector is set. The load drives are active low. The power calculation that produces the contributions is done upstream. A phase-0 sample strobe with a polarity flag tells the block where each mains cycle begins and when each negative half begins.

Top module: `load_diverter`

## Requirements
- R1: While `rst` is high, every bit of `load_n` is driven to 1 (all loads off), `level` is 0, and the priority mode takes the value of `sel_swap`. The first clock edge after release sees all load counters at zero, an active load of 0 and a recorded transition level equal to the mid-point.
- R2: Each `contrib_valid` cycle adds the signed `contrib_value` to `level`. When `contrib_phase` is 0, `REQUIRED_EXPORT` is also subtracted. The result is clamped to the range 0 to `CAPACITY` (default 180000). It is visible on `level` one cycle later.
- R3: A phase-0 sample with `ph0_positive`=1 that follows a negative sample (or reset) opens a positive half. The load decision runs on the positive sample that has exactly 5 earlier positive samples in the same half. `load_n` changes only one cycle after the cycle in which that decision is taken.
- R4: At each decision, both load counters are incremented first. The level is upper half only when it is strictly above `CAPACITY/2`. A change of half from the previous decision (lower half after reset) sets the crossing counter to 0. No load changes unless the crossing counter is then greater than 10.
- R5: In the upper half, a load is added only if `level` is at or above the recorded transition level. Loads are scanned from index 0 upward, and the first off load is turned on if it is the active load or the timeout holds.
- R6: In the lower half, a load is removed only if `level` is at or below the recorded transition level. Loads are scanned from the highest index down, and the first on load is turned off if it is the active load or the timeout holds.
- R7: At most one logical load changes per decision. A change records the current level, clears the change counter and makes the switched load the active load.
- R8: `load_n[i]` is the inverse of logical load i. With swapped mode, bits 0 and 1 take logical loads 1 and 0. The mapping in force is applied to `load_n` only at a decision.
- R9: At every start of a negative half on phase 0, a mismatch between `sel_swap` and the mode increments a filter counter. Matching samples leave the counter alone. When it reaches 20 the mode takes `sel_swap` and the counter clears (1 = swapped).
- R10: The timeout holds when the change counter, after its increment at the decision, is greater than 25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| contrib_valid | input | 1 | One energy contribution this cycle |
| contrib_phase | input | 2 | Phase index of the contribution |
| contrib_value | input | CONTRIB_W | Signed contribution, energy units |
| ph0_sample | input | 1 | A phase-0 voltage sample is present |
| ph0_positive | input | 1 | Polarity of that sample, 1 = positive |
| sel_swap | input | 1 | Priority selector, 1 = load 1 first |
| load_n | output | N_LOADS | Active-low load drives |
| level | output | LEVEL_W | Clamped energy level |

## Verification
The assertions take for granted that contributions and phase-0 samples never fall in the same cycle. This matters because a decision reads the level as registered before that cycle. They also assume that a decision and a negative-half start cannot coincide, which the single sample strobe guarantees. The stimulus keeps to this by presenting contributions and samples as separate one-cycle pulses with idle cycles between them. Each mains cycle is built as a burst of contributions, then eight positive samples, then eight negative ones. Drift phases push the level through both clamps and back across the mid-point, so settling, trend and timeout rules all come into play.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        HALF_LOWER = 1'b0,
        HALF_UPPER = 1'b1
    } half_e;

    typedef enum logic {
        MAP_DIRECT  = 1'b0,
        MAP_SWAPPED = 1'b1
    } map_e;

    typedef logic [3:0] load_idx_t;

    typedef struct packed {
        logic      hit;
        load_idx_t idx;
    } pick_t;

    // Lowest-index off load that may switch on.
    function automatic pick_t pick_on(input logic [15:0] on, input int n,
                                      input load_idx_t active, input logic tmo);
        pick_t r;
        r = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < n && !r.hit && !on[i] && (active == i[3:0] || tmo)) begin
                r.hit = 1'b1;
                r.idx = i[3:0];
            end
        end
        return r;
    endfunction

    // Highest-index on load that may switch off.
    function automatic pick_t pick_off(input logic [15:0] on, input int n,
                                       input load_idx_t active, input logic tmo);
        pick_t r;
        r = '0;
        for (int i = 15; i >= 0; i--) begin
            if (i < n && !r.hit && on[i] && (active == i[3:0] || tmo)) begin
                r.hit = 1'b1;
                r.idx = i[3:0];
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] clamp_level(input logic signed [31:0] v,
                                                input logic [31:0] cap);
        if (v < 0) return '0;
        if ($unsigned(v) > cap) return cap;
        return $unsigned(v);
    endfunction

endpackage

// File: rtl/div_energy_acc.sv
module div_energy_acc #(
    parameter int LEVEL_W         = 18,
    parameter int CONTRIB_W       = 16,
    parameter int CAPACITY        = 180000,
    parameter int REQUIRED_EXPORT = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        valid,
    input  logic [1:0]                  phase,
    input  logic signed [CONTRIB_W-1:0] value,
    output logic [LEVEL_W-1:0]          level
);
    localparam logic signed [31:0] EXPORT_S = 32'(REQUIRED_EXPORT);
    localparam logic [31:0]        CAP_U    = 32'(CAPACITY);

    logic signed [31:0] sum_s;
    logic [31:0]        lvl_d;

    always_comb begin
        sum_s = $signed({{(32-LEVEL_W){1'b0}}, level})
              + $signed({{(32-CONTRIB_W){value[CONTRIB_W-1]}}, value});
        if (phase == 2'd0) sum_s = sum_s - EXPORT_S;
        lvl_d = div_pkg::clamp_level(sum_s, CAP_U);
    end

    always_ff @(posedge clk) begin
        if (rst)        level <= '0;
        else if (valid) level <= lvl_d[LEVEL_W-1:0];
    end
endmodule

// File: rtl/div_mains_timing.sv
module div_mains_timing #(
    parameter int EVAL_SAMPLE = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic positive,
    output logic eval_pulse,
    output logic neg_pulse
);
    localparam int CNT_W = $clog2(EVAL_SAMPLE + 2);

    logic             last_pos;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] chk;

    always_comb chk = last_pos ? cnt : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos   <= 1'b0;
            cnt        <= '0;
            eval_pulse <= 1'b0;
            neg_pulse  <= 1'b0;
        end else begin
            eval_pulse <= 1'b0;
            neg_pulse  <= 1'b0;
            if (sample) begin
                last_pos <= positive;
                if (positive) begin
                    eval_pulse <= (chk == CNT_W'(EVAL_SAMPLE));
                    if (chk != '1) cnt <= chk + 1'b1;
                    else           cnt <= chk;
                end else begin
                    neg_pulse <= last_pos;
                end
            end
        end
    end
endmodule

// File: rtl/div_prio_filter.sv
module div_prio_filter #(
    parameter int DEBOUNCE = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              neg_pulse,
    input  logic              sel,
    output div_pkg::map_e     mode
);
    localparam int CNT_W = $clog2(DEBOUNCE + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    always_comb cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= div_pkg::map_e'(sel);
            cnt  <= '0;
        end else if (neg_pulse && (sel != mode)) begin
            if (cnt_inc >= CNT_W'(DEBOUNCE)) begin
                mode <= div_pkg::map_e'(sel);
                cnt  <= '0;
            end else begin
                cnt <= cnt_inc;
            end
        end
    end
endmodule

// File: rtl/div_load_select.sv
module div_load_select #(
    parameter int N_LOADS  = 3,
    parameter int LEVEL_W  = 18,
    parameter int CAPACITY = 180000,
    parameter int SETTLE   = 10,
    parameter int SPACING  = 25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               eval_pulse,
    input  logic [LEVEL_W-1:0] level,
    input  div_pkg::map_e      mode,
    output logic [N_LOADS-1:0] logic_on,
    output logic [N_LOADS-1:0] load_n
);
    import div_pkg::*;

    localparam int LIM   = (SETTLE > SPACING ? SETTLE : SPACING) + 2;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam logic [LEVEL_W-1:0] MID = LEVEL_W'(CAPACITY / 2);

    logic [CNT_W-1:0]   cross_q, change_q, cross_d, change_d;
    half_e              half_q, half_d;
    load_idx_t          active_q, active_d;
    logic [LEVEL_W-1:0] rec_q, rec_d;
    logic [N_LOADS-1:0] on_d, phys;
    logic               tmo, act;
    pick_t              p;

    always_comb begin
        cross_d  = (cross_q  == '1) ? cross_q  : cross_q  + 1'b1;
        change_d = (change_q == '1) ? change_q : change_q + 1'b1;
        half_d   = (level > MID) ? HALF_UPPER : HALF_LOWER;
        if (half_d != half_q) cross_d = '0;
        tmo      = change_d > CNT_W'(SPACING);
        act      = cross_d > CNT_W'(SETTLE);
        on_d     = logic_on;
        active_d = active_q;
        rec_d    = rec_q;
        p        = '0;
        if (act) begin
            if (half_d == HALF_UPPER && level >= rec_q)
                p = pick_on(16'(logic_on), N_LOADS, active_q, tmo);
            else if (half_d == HALF_LOWER && level <= rec_q)
                p = pick_off(16'(logic_on), N_LOADS, active_q, tmo);
        end
        if (p.hit) begin
            for (int i = 0; i < N_LOADS; i++)
                if (p.idx == 4'(i)) on_d[i] = (half_d == HALF_UPPER);
            change_d = '0;
            rec_d    = level;
            active_d = p.idx;
        end
        phys = on_d;
        if (mode == MAP_SWAPPED) begin
            phys[0] = on_d[1];
            phys[1] = on_d[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cross_q  <= '0;
            change_q <= '0;
            half_q   <= HALF_LOWER;
            active_q <= '0;
            rec_q    <= MID;
            logic_on <= '0;
            load_n   <= '1;
        end else if (eval_pulse) begin
            cross_q  <= cross_d;
            change_q <= change_d;
            half_q   <= half_d;
            active_q <= active_d;
            rec_q    <= rec_d;
            logic_on <= on_d;
            load_n   <= ~phys;
        end
    end
endmodule

// File: rtl/load_diverter.sv
module load_diverter #(
    parameter int N_LOADS         = 3,
    parameter int LEVEL_W         = 18,
    parameter int CONTRIB_W       = 16,
    parameter int CAPACITY        = 180000,
    parameter int REQUIRED_EXPORT = 0,
    parameter int EVAL_SAMPLE     = 5,
    parameter int SETTLE          = 10,
    parameter int SPACING         = 25,
    parameter int DEBOUNCE        = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        contrib_valid,
    input  logic [1:0]                  contrib_phase,
    input  logic signed [CONTRIB_W-1:0] contrib_value,
    input  logic                        ph0_sample,
    input  logic                        ph0_positive,
    input  logic                        sel_swap,
    output logic [N_LOADS-1:0]          load_n,
    output logic [LEVEL_W-1:0]          level
);
    logic               eval_pulse, neg_pulse;
    div_pkg::map_e      mode;
    logic [N_LOADS-1:0] logic_on;

    div_energy_acc #(
        .LEVEL_W(LEVEL_W), .CONTRIB_W(CONTRIB_W),
        .CAPACITY(CAPACITY), .REQUIRED_EXPORT(REQUIRED_EXPORT)
    ) u_acc (
        .clk(clk), .rst(rst), .valid(contrib_valid),
        .phase(contrib_phase), .value(contrib_value), .level(level)
    );

    div_mains_timing #(.EVAL_SAMPLE(EVAL_SAMPLE)) u_timing (
        .clk(clk), .rst(rst), .sample(ph0_sample), .positive(ph0_positive),
        .eval_pulse(eval_pulse), .neg_pulse(neg_pulse)
    );

    div_prio_filter #(.DEBOUNCE(DEBOUNCE)) u_prio (
        .clk(clk), .rst(rst), .neg_pulse(neg_pulse), .sel(sel_swap), .mode(mode)
    );

    div_load_select #(
        .N_LOADS(N_LOADS), .LEVEL_W(LEVEL_W), .CAPACITY(CAPACITY),
        .SETTLE(SETTLE), .SPACING(SPACING)
    ) u_select (
        .clk(clk), .rst(rst), .eval_pulse(eval_pulse), .level(level),
        .mode(mode), .logic_on(logic_on), .load_n(load_n)
    );
endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int N_LOADS  = 3,
    parameter int LEVEL_W  = 18,
    parameter int CAPACITY = 180000
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LOADS-1:0] load_n,
    input logic [LEVEL_W-1:0] level,
    input logic               eval_pulse,
    input logic               neg_pulse,
    input logic [N_LOADS-1:0] logic_on,
    input div_pkg::map_e      mode
);
    // R1: reset state of the outputs
    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> (load_n == '1 && level == '0));

    // R2: level never exceeds the capacity
    a_r2_level_bounded: assert property (@(posedge clk) disable iff (rst)
        level <= LEVEL_W'(CAPACITY));

    // R3: drives move only right after a decision
    a_r3_change_after_eval: assert property (@(posedge clk) disable iff (rst)
        (load_n != $past(load_n)) |-> $past(eval_pulse));

    // R7: one logical load per decision
    a_r7_single_change: assert property (@(posedge clk) disable iff (rst)
        $countones(logic_on ^ $past(logic_on)) <= 1);

    // R9: mode moves only after a negative-half start
    a_r9_mode_on_neg_start: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |-> $past(neg_pulse));
endmodule

bind load_diverter div_checker #(
    .N_LOADS(N_LOADS), .LEVEL_W(LEVEL_W), .CAPACITY(CAPACITY)
) u_div_checker (
    .clk(clk), .rst(rst), .load_n(load_n), .level(level),
    .eval_pulse(eval_pulse), .neg_pulse(neg_pulse),
    .logic_on(logic_on), .mode(mode)
);

// File: tb/test_load_diverter.sv
module test_load_diverter;
    localparam int NL   = 3;
    localparam int CAP  = 180000;
    localparam int MIDV = CAP / 2;
    localparam int EXP  = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        contrib_valid = 1'b0;
    logic [1:0]  contrib_phase = '0;
    logic signed [15:0] contrib_value = '0;
    logic        ph0_sample = 1'b0;
    logic        ph0_positive = 1'b0;
    logic        sel_swap = 1'b1;
    logic [NL-1:0] load_n;
    logic [17:0] level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    load_diverter #(.REQUIRED_EXPORT(EXP)) i_load_diverter (
        .clk(clk), .rst(rst), .contrib_valid(contrib_valid),
        .contrib_phase(contrib_phase), .contrib_value(contrib_value),
        .ph0_sample(ph0_sample), .ph0_positive(ph0_positive),
        .sel_swap(sel_swap), .load_n(load_n), .level(level)
    );

    // Reference model state
    int m_lvl, m_rec, m_cross, m_change, m_active, m_dbc, m_cnt;
    bit m_upper, m_mode, m_lastpos;
    bit m_on [NL];
    string m_tag;

    function automatic void m_reset();
        m_lvl = 0; m_rec = MIDV; m_cross = 0; m_change = 0; m_active = 0;
        m_dbc = 0; m_cnt = 0; m_upper = 0; m_mode = sel_swap; m_lastpos = 0;
        for (int i = 0; i < NL; i++) m_on[i] = 0;
    endfunction

    function automatic logic [NL-1:0] m_drive();
        logic [NL-1:0] ph;
        for (int i = 0; i < NL; i++) ph[i] = m_on[i];
        if (m_mode) begin ph[0] = m_on[1]; ph[1] = m_on[0]; end
        return ~ph;
    endfunction

    function automatic void m_contrib(int ph, int v);
        m_lvl = m_lvl + v - (ph == 0 ? EXP : 0);
        if (m_lvl < 0) m_lvl = 0;
        if (m_lvl > CAP) m_lvl = CAP;
    endfunction

    function automatic void m_eval();
        bit up, tmo;
        int pick;
        m_cross = (m_cross < 1000) ? m_cross + 1 : m_cross;
        m_change = (m_change < 1000) ? m_change + 1 : m_change;
        up = (m_lvl > MIDV);
        if (up != m_upper) m_cross = 0;
        m_upper = up;
        tmo = (m_change > 25);
        pick = -1;
        m_tag = "R4";
        if (m_cross > 10) begin
            m_tag = "R3";
            if (up && m_lvl >= m_rec) begin
                for (int i = 0; i < NL; i++)
                    if (pick < 0 && !m_on[i] && (i == m_active || tmo)) pick = i;
            end else if (!up && m_lvl <= m_rec) begin
                for (int i = NL - 1; i >= 0; i--)
                    if (pick < 0 && m_on[i] && (i == m_active || tmo)) pick = i;
            end
        end
        if (pick >= 0) begin
            m_tag = (pick != m_active) ? "R10" : (up ? "R5" : "R6");
            m_on[pick] = up;
            m_change = 0;
            m_rec = m_lvl;
            m_active = pick;
        end
    endfunction

    function automatic void m_neg();
        if (sel_swap != m_mode) begin
            m_dbc++;
            if (m_dbc >= 20) begin m_mode = sel_swap; m_dbc = 0; end
        end
    endfunction

    function automatic bit m_sample(bit pos);
        int chk;
        bit ev;
        ev = 0;
        if (pos) begin
            chk = m_lastpos ? m_cnt : 0;
            ev = (chk == 5);
            m_cnt = (chk < 7) ? chk + 1 : chk;
            if (ev) m_eval();
        end else if (m_lastpos) begin
            m_neg();
        end
        m_lastpos = pos;
        return ev;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_contrib(int ph, int v);
        contrib_valid = 1'b1;
        contrib_phase = 2'(ph);
        contrib_value = 16'(v);
        @(negedge clk);
        contrib_valid = 1'b0;
        m_contrib(ph, v);
        check("R2 level", level, m_lvl);
    endtask

    bit prev_mode;
    logic [NL-1:0] prev_drive;

    task automatic do_sample(bit pos);
        bit ev;
        ph0_sample = 1'b1;
        ph0_positive = pos;
        @(negedge clk);
        ph0_sample = 1'b0;
        @(negedge clk);
        ev = m_sample(pos);
        if (ev) begin
            if (m_mode != prev_mode) check("R9 mapping", load_n, m_drive());
            else if (m_on[0] != m_on[1] && m_mode) check("R8 swapped drive", load_n, m_drive());
            else check({m_tag, " drive"}, load_n, m_drive());
            if (m_mode == prev_mode)
                check("R7 one change", ($countones(load_n ^ prev_drive) <= 1), 1);
            prev_mode = m_mode;
            prev_drive = load_n;
        end else begin
            check("R3 hold", load_n, prev_drive);
        end
    endtask

    task automatic mains_cycle(int drift, int npos);
        for (int ph = 0; ph < 3; ph++)
            do_contrib(ph, drift + int'($urandom % 4001) - 2000);
        for (int s = 0; s < npos; s++) do_sample(1);
        for (int s = 0; s < 8; s++) do_sample(0);
    endtask

    initial begin
        int drift;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        m_reset();
        rst = 1'b0;
        @(negedge clk);
        check("R1 drive", load_n, 3'b111);
        check("R1 level", level, 0);
        prev_mode = m_mode;
        prev_drive = load_n;

        // directed: clamp at both ends, export subtraction
        do_contrib(1, -5000);
        check("R2 floor", level, 0);
        for (int k = 0; k < 7; k++) do_contrib(2, 30000);
        check("R2 ceiling", level, CAP);
        do_contrib(0, 0);
        check("R2 export", level, CAP - EXP);

        // short positive half: no decision (R3)
        mains_cycle(0, 5);
        // drive upward to switch loads on
        for (int c = 0; c < 30; c++) mains_cycle(6000, 8);
        for (int c = 0; c < 40; c++) mains_cycle(-6000, 8);

        for (int c = 0; c < 560; c++) begin
            if (c % 25 == 0) drift = (int'($urandom % 3) - 1) * 3500;
            if (c % 150 == 60) sel_swap = ~sel_swap;
            if (c % 150 == 130) sel_swap = ~sel_swap;
            if (c == 300) begin
                // toggle back early: filter counter keeps its count (R9)
                sel_swap = ~sel_swap;
                for (int k = 0; k < 10; k++) mains_cycle(drift, 8);
                sel_swap = ~sel_swap;
            end
            mains_cycle(drift, (c % 37 == 5) ? 4 : 8);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule